// File: doc/BRIEF.md
# Redundant PCM Line Mismatch Detector

This block watches two pairs of redundant serial PCM receive lines, one bit sample per clock. Lines 0 and 1 form pair 0 and lines 2 and 3 form pair 1. When the two lines of a pair that is enabled for comparison disagree, the block raises a level interrupt. It also captures an 8-bit status word. The status word carries a pair flag and a location code. The location code gives the time slot and the group of bits in which the disagreement was seen.

The block keeps its own frame position. A frame sync pulse marks the first bit of slot 0. Bits arrive MSB first, and the slot count wraps at the programmed number of slots per frame. A mode input selects how finely the location is reported: a whole byte, a nibble or a bit pair. The slot part of the location code is stored with a mode-dependent offset. After the interrupt, software reads the status with a read strobe, and that read re-arms the detector. To find out which line of the pair is actually faulty, software has to send a known pattern and compare it.

Top module: `pcm_pair_mismatch`

## Requirements
- R1: After reset, `irq` is low.
- R2: A pair whose bit in `cmp_en` is 0 never raises `irq`. Bit 0 enables pair 0 (lines 0/1) and bit 1 enables pair 1 (lines 2/3).
- R3: `status[7]` is 0 for a mismatch between lines 0 and 1, and 1 for a mismatch between lines 2 and 3.
- R4: In mode 0 (byte grain), `status[6:0]` = (slot − 8) mod `slots_per_frame`.
- R5: In mode 1 (nibble grain), `status[6:1]` = (slot − 4) mod `slots_per_frame`. `status[0]` is 1 for bits 3..0 and 0 for bits 7..4. For example, slot 13 bit 2 on pair 0 gives status 8'h13.
- R6: In mode 2 (bit-pair grain), `status[6:2]` = (slot − 2) mod `slots_per_frame`. `status[1:0]` is 11 for bits 1..0, 10 for bits 3..2, 01 for bits 5..4 and 00 for bits 7..6.
- R7: `irq` rises on the clock edge that samples a mismatch, stays high until `rd_stb`, and is low from the edge that samples `rd_stb`.
- R8: While `irq` is high, further mismatches are ignored. The status keeps the first one, and none of them raises `irq` after the read.
- R9: When both enabled pairs mismatch in the same bit period, pair 0 is reported (`status[7]` = 0).
- R10: `fsync` high on a clock edge marks that sample as slot 0, bit 7. Later samples step bits 7 down to 0 and then go to the next slot. The slot wraps to 0 after `slots_per_frame` − 1 without a new `fsync`. `slots_per_frame` must be at least 8.
- R11: Mode 3 reports in the same way as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame start, marks slot 0 bit 7 |
| rxd | input | 4 | Receive lines; [1:0] pair 0, [3:2] pair 1 |
| cmp_en | input | 2 | Per-pair comparison enable |
| mode | input | 2 | Report grain: 0 byte, 1 nibble, 2 bit pair, 3 as 0 |
| slots_per_frame | input | SLOT_W | Number of time slots per frame |
| rd_stb | input | 1 | Status read strobe, re-arms the interrupt |
| irq | output | 1 | Mismatch interrupt, level |
| status | output | 8 | Pair flag [7] and location code [6:0] |

## Verification
The bench builds the block with the default 7-bit slot width and programs 16 and 32 slots per frame. These short frames keep the runs brief. With them, low slot numbers make the offset subtraction wrap past zero in every mode. A sample placed beyond the end of the first frame, with no second frame sync, checks the slot counter's own wrap. Every bit position is walked in bit-pair mode, so each two-bit group code is reached.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

  localparam int NPAIRS = 2;
  localparam int LINES  = 2 * NPAIRS;
  localparam int LOC_W  = 7;

  typedef enum logic [1:0] {
    GRAIN_BYTE   = 2'd0,
    GRAIN_NIBBLE = 2'd1,
    GRAIN_BPAIR  = 2'd2,
    GRAIN_ALT    = 2'd3
  } grain_e;

  typedef struct packed {
    logic             pair;
    logic [LOC_W-1:0] loc;
  } pmd_status_t;

endpackage

// File: rtl/pmd_rst_sync.sv
module pmd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/pmd_frame_timer.sv
module pmd_frame_timer #(
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              fsync,
  input  logic [SLOT_W-1:0] spf,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [2:0]        cur_bit
);

  localparam int EXT_W = SLOT_W + 1;

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [2:0]        idx_q, idx_d;
  logic [SLOT_W-1:0] pos_slot;
  logic [2:0]        pos_idx;
  logic [EXT_W-1:0]  slot_inc;
  logic              adv_en;

  // Position of the sample taken on this edge
  always_comb begin
    pos_slot = fsync ? '0 : slot_q;
    pos_idx  = fsync ? 3'd0 : idx_q;
  end

  assign cur_slot = pos_slot;
  assign cur_bit  = 3'd7 - pos_idx;   // MSB received first

  // Next-state logic
  always_comb begin
    adv_en   = 1'b1;
    slot_inc = {1'b0, pos_slot} + EXT_W'(1);
    slot_d   = slot_q;
    idx_d    = idx_q;
    if (adv_en) begin
      if (pos_idx == 3'd7) begin
        idx_d  = 3'd0;
        slot_d = (slot_inc >= {1'b0, spf}) ? '0 : slot_inc[SLOT_W-1:0];
      end else begin
        idx_d  = pos_idx + 3'd1;
        slot_d = pos_slot;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      slot_q <= '0;
      idx_q  <= 3'd0;
    end else if (adv_en) begin
      slot_q <= slot_d;
      idx_q  <= idx_d;
    end
  end

  AST_FSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_sn)
    fsync |=> (idx_q == 3'd1 && slot_q == '0)); // R10

  AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_sn)
    (!fsync && $stable(spf) && slot_q < spf && idx_q == 3'd7) |=> (slot_q < spf)); // R10

endmodule

// File: rtl/pmd_loc_encoder.sv
module pmd_loc_encoder
  import pmd_pkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic [1:0]        mode,
  input  logic [SLOT_W-1:0] spf,
  input  logic [SLOT_W-1:0] slot,
  input  logic [2:0]        bit_num,
  output logic [LOC_W-1:0]  loc
);

  localparam int EXT_W = SLOT_W + 1;

  grain_e            grain;
  logic [EXT_W-1:0]  offset;
  logic [EXT_W-1:0]  shifted;
  logic [LOC_W-1:0]  code;
  logic              low_nib;
  logic [1:0]        pair_sel;

  assign grain = grain_e'(mode);

  always_comb begin
    unique case (grain)
      GRAIN_NIBBLE: offset = EXT_W'(4);
      GRAIN_BPAIR:  offset = EXT_W'(2);
      default:      offset = EXT_W'(8);
    endcase
  end

  // (slot - offset) mod spf, with slot < spf and spf >= offset
  always_comb begin
    if ({1'b0, slot} >= offset) shifted = {1'b0, slot} - offset;
    else                        shifted = {1'b0, slot} + {1'b0, spf} - offset;
    code = LOC_W'(shifted);
  end

  always_comb begin
    low_nib  = (bit_num <= 3'd3);
    pair_sel = 2'd3 - bit_num[2:1];
  end

  always_comb begin
    unique case (grain)
      GRAIN_NIBBLE: loc = {code[LOC_W-2:0], low_nib};
      GRAIN_BPAIR:  loc = {code[LOC_W-3:0], pair_sel};
      default:      loc = code;
    endcase
  end

endmodule

// File: rtl/pmd_irq_status.sv
module pmd_irq_status
  import pmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [NPAIRS-1:0] mism,
  input  logic [LOC_W-1:0]  loc,
  input  logic              rd_stb,
  output logic              irq,
  output pmd_status_t       status
);

  logic        irq_q, irq_d;
  pmd_status_t stat_q, stat_d;
  logic        capture;

  // Next-state logic
  always_comb begin
    capture = !irq_q && (|mism);
    irq_d   = irq_q;
    stat_d  = stat_q;
    if (capture) begin
      irq_d       = 1'b1;
      stat_d.pair = !mism[0];   // pair 0 wins a tie
      stat_d.loc  = loc;
    end else if (irq_q && rd_stb) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  // Status has no reset value; written only on capture
  always_ff @(posedge clk) begin
    if (capture) stat_q <= stat_d;
  end

  assign irq    = irq_q;
  assign status = stat_q;

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_sn)
    (!irq_q && (|mism)) |=> irq_q); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq_q && !rd_stb) |=> irq_q); // R7

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq_q && rd_stb) |=> !irq_q); // R7

  AST_KEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_q |=> $stable(stat_q)); // R8

  AST_PAIR0_PRIO: assert property (@(posedge clk) disable iff (!rst_sn)
    (!irq_q && mism[0]) |=> !stat_q.pair); // R9

  AST_PAIR1_FLAG: assert property (@(posedge clk) disable iff (!rst_sn)
    (!irq_q && mism == 2'b10) |=> stat_q.pair); // R3

endmodule

// File: rtl/pcm_pair_mismatch.sv
module pcm_pair_mismatch
  import pmd_pkg::*;
#(
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic [3:0]        rxd,
  input  logic [1:0]        cmp_en,
  input  logic [1:0]        mode,
  input  logic [SLOT_W-1:0] slots_per_frame,
  input  logic              rd_stb,
  output logic              irq,
  output logic [7:0]        status
);

  logic              rst_sn;
  logic [SLOT_W-1:0] cur_slot;
  logic [2:0]        cur_bit;
  logic [LOC_W-1:0]  loc;
  logic [NPAIRS-1:0] mism;
  pmd_status_t       stat;

  pmd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  pmd_frame_timer #(.SLOT_W(SLOT_W)) u_timer (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .fsync    (fsync),
    .spf      (slots_per_frame),
    .cur_slot (cur_slot),
    .cur_bit  (cur_bit)
  );

  genvar p;
  generate
    for (p = 0; p < NPAIRS; p++) begin : g_pair
      assign mism[p] = cmp_en[p] & (rxd[2*p] ^ rxd[2*p+1]);
    end
  endgenerate

  pmd_loc_encoder #(.SLOT_W(SLOT_W)) u_enc (
    .mode    (mode),
    .spf     (slots_per_frame),
    .slot    (cur_slot),
    .bit_num (cur_bit),
    .loc     (loc)
  );

  pmd_irq_status u_stat (
    .clk    (clk),
    .rst_sn (rst_sn),
    .mism   (mism),
    .loc    (loc),
    .rd_stb (rd_stb),
    .irq    (irq),
    .status (stat)
  );

  assign status = stat;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (!irq && cmp_en == 2'b00) |=> !irq); // R2

endmodule

// File: tb/tb_pcm_pair_mismatch.sv
module tb_pcm_pair_mismatch;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fsync;
  logic [3:0] rxd;
  logic [1:0] cmp_en;
  logic [1:0] mode;
  logic [6:0] spf;
  logic       rd_stb;
  logic       irq;
  logic [7:0] status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  bit irq_seen = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  pcm_pair_mismatch dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd), .cmp_en(cmp_en),
    .mode(mode), .slots_per_frame(spf), .rd_stb(rd_stb), .irq(irq), .status(status)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(input int md, input int sp, input int abs_slot,
                                          input int bitn, input int which);
    int s, off, v, loc;
    s   = abs_slot % sp;
    off = (md == 1) ? 4 : (md == 2) ? 2 : 8;
    v   = s - off;
    if (v < 0) v += sp;
    if (md == 1)      loc = ((v & 63) << 1) | ((bitn <= 3) ? 1 : 0);
    else if (md == 2) loc = ((v & 31) << 2) | (3 - bitn / 2);
    else              loc = v & 127;
    return {(which == 2) ? 1'b1 : 1'b0, loc[6:0]};
  endfunction

  // Monitor: compares each interrupt against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && irq && !irq_seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R8 unexpected irq", status, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(status == e, t, status, e);
      end
    end
    irq_seen = irq;
  end

  // Driver: frame sync, then one disagreeing sample at the target position
  task automatic inject(input int md, input int sp, input int abs_slot, input int bitn,
                        input int which, input logic [1:0] en, input bit expect_irq,
                        input string tag);
    int k;
    @(negedge clk);
    mode = md[1:0]; spf = sp[6:0]; cmp_en = en; fsync = 1'b1;
    k = abs_slot * 8 + (7 - bitn);
    if (k > 0) begin
      @(negedge clk);
      fsync = 1'b0;
      repeat (k - 1) @(negedge clk);
    end
    if (expect_irq) begin
      exp_q.push_back(exp_code(md, sp, abs_slot, bitn, which));
      tag_q.push_back(tag);
    end
    rxd = {which[1], 1'b0, which[0], 1'b0};
    @(negedge clk);
    fsync = 1'b0;
    rxd = 4'b0000;
  endtask

  task automatic do_read(input string tag);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check(irq == 1'b0, tag, irq, 0);
  endtask

  initial begin
    rst_n = 1'b0; fsync = 1'b0; rxd = 4'b0000; cmp_en = 2'b00;
    mode = 2'd0; spf = 7'd32; rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(irq == 1'b0, "R1 reset irq", irq, 0);

    // R5 worked example: slot 13 bit 2, pair 0
    inject(1, 32, 13, 2, 1, 2'b11, 1, "R5 example");
    check(status == 8'h13, "R5 example code", status, 8'h13);
    repeat (10) @(negedge clk);
    check(irq == 1'b1, "R7 irq held", irq, 1);
    do_read("R7 irq clears after read");
    @(negedge clk);
    check(irq == 1'b0, "R7 read on idle", irq, 0);

    // R4 byte grain, pair 1, with and without offset wrap (R3 flag)
    inject(0, 32, 20, 0, 2, 2'b11, 1, "R4/R3 byte slot 20 pair1");
    do_read("R7 read");
    inject(0, 32, 3, 5, 1, 2'b01, 1, "R4 byte slot 3 wrap");
    do_read("R7 read");

    // R5 high nibble with wrap
    inject(1, 32, 2, 6, 1, 2'b01, 1, "R5 nibble high wrap");
    do_read("R7 read");

    // R6 every bit position
    for (int b = 0; b < 8; b++) begin
      inject(2, 32, 5, b, 1, 2'b01, 1, "R6 bit pair");
      do_read("R7 read");
    end
    inject(2, 32, 1, 0, 2, 2'b10, 1, "R6 bit pair wrap pair1");
    do_read("R7 read");

    // R2 disabled pairs stay quiet
    inject(0, 32, 9, 4, 1, 2'b10, 0, "R2");
    repeat (4) @(negedge clk);
    check(irq == 1'b0, "R2 pair0 disabled", irq, 0);
    inject(0, 32, 9, 4, 2, 2'b01, 0, "R2");
    repeat (4) @(negedge clk);
    check(irq == 1'b0, "R2 pair1 disabled", irq, 0);

    // R9 both pairs at once
    inject(0, 32, 11, 7, 3, 2'b11, 1, "R9 pair0 priority");
    do_read("R7 read");

    // R8 later mismatches ignored while pending
    inject(1, 32, 7, 1, 1, 2'b11, 1, "R8 first kept");
    inject(1, 32, 9, 6, 2, 2'b11, 0, "R8");
    check(status == exp_code(1, 32, 7, 1, 1), "R8 status holds first", status,
          exp_code(1, 32, 7, 1, 1));
    do_read("R7 read");
    repeat (5) @(negedge clk);
    check(irq == 1'b0, "R8 no late irq", irq, 0);

    // R10 slot wrap without a second frame sync
    inject(0, 16, 21, 3, 1, 2'b01, 1, "R10 slot wrap");
    do_read("R7 read");

    // R11 mode 3 matches mode 0
    inject(3, 16, 4, 2, 2, 2'b10, 1, "R11 mode 3");
    do_read("R7 read");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 missing irq", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule